// File: doc/BRIEF.md
# Legacy Memory Window Router

This block is the part of a host bridge that decides where accesses to the legacy area below 1 MiB are sent. It holds a small, sparse, byte-addressable configuration space. Software writes it through a 32-bit dword port with byte enables. The space contains seven attribute bytes, an SMRAM control byte and a read-only memory-size byte.

For every memory address presented, the block computes two routing bits: one for reads and one for writes. Each bit says whether that kind of access goes to DRAM or to the PCI side. Normal cycles and system-management cycles get separate views of the 0xA0000–0xBFFFF window. The BIOS segment and the twelve expansion segments each follow their own 2-bit attribute field.

The routing map is a snapshot. It is loaded only when a configuration write lands on the attribute bytes or on the SMRAM byte. A request sampled on the same clock edge as that write still sees the old map.

Top module: `legacy_route_ctl`

## Requirements
- R1: While and after reset, both routing outputs and the read data are 0. The SMRAM byte (offset 0x72) reads 0x02 and all attribute bytes read 0x00, so after reset every access in 0xA0000–0xFFFFF goes to PCI for both normal and system-management cycles.
- R2: Offset 0x57 reads min(RAM_MB/8, 255). Writes to it are ignored. With the default RAM_MB=512 it reads 0x40, and with RAM_MB=4096 it reads 0xFF.
- R3: A write with cfg_wr high at a rising edge updates every byte whose enable is set. Lane j of dword cfg_dw is offset 4*cfg_dw+j, carried on cfg_wdata[8j+7:8j]. Only offsets 0x59–0x5F and 0x72 are writable, and all 8 bits of each are stored. Every other offset reads 0 and ignores writes. cfg_rdata returns dword cfg_dw one edge after it is presented.
- R4: Region 0 is 0xF0000–0xFFFFF and takes its field from bits [5:4] of offset 0x59. Bits [3:0] of 0x59 have no effect on routing. Region i (1..12) is the 16 KiB segment starting at 0xC0000+(i-1)*0x4000. It uses the byte at 0x59+ceil(i/2): bits [1:0] when i is odd and bits [5:4] when i is even.
- R5: Bit 0 of a field set to 1 routes reads to DRAM, and set to 0 routes them to PCI. Bit 1 does the same for writes. Fields apply identically to normal and system-management cycles.
- R6: For normal cycles (mem_smm=0) in 0xA0000–0xBFFFF, both reads and writes go to DRAM when bit 6 (open) of 0x72 is set, and to PCI otherwise.
- R7: For system-management cycles (mem_smm=1) in 0xA0000–0xBFFFF, both go to DRAM when bit 3 (global enable) or bit 6 (open) of 0x72 is set, and to PCI otherwise.
- R8: Addresses below 0xA0000 or at or above 0x100000 route both reads and writes to DRAM, whatever the register contents.
- R9: The routing map is reloaded only by a write with an enabled byte at 0x59–0x5F or 0x72. A request sampled on the edge of that write uses the previous map, and a request sampled on the next edge uses the new one.
- R10: route_rd_dram and route_wr_dram are registered. They show the routing of the address and mode sampled at the previous rising edge and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index (offset / 4) |
| cfg_be | input | 4 | Byte enables, lane j = offset 4*cfg_dw+j |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data of dword cfg_dw |
| mem_addr | input | ADDR_W | Memory address to route |
| mem_smm | input | 1 | Access is a system-management cycle |
| route_rd_dram | output | 1 | 1: reads to DRAM, 0: reads to PCI |
| route_wr_dram | output | 1 | 1: writes to DRAM, 0: writes to PCI |

## Verification
The bench sweeps every segment in both cycle modes under many attribute patterns and all four open/global-enable combinations, predicting each route from the segment arithmetic. This catches a design that pairs the wrong nibble with a segment or swaps the read and write bits. It writes the reserved low nibble of the first attribute byte, masked lanes and non-attribute offsets. A design that decoded these, or reloaded the map on any write, would move the BIOS route or change routes it must leave alone. It checks that a request sampled on the edge of an attribute write still gets the old route and that outputs hold between edges, which exposes a map that updates combinationally or a missing output register. It also reads the memory-size byte after an attempted write and with a value that must saturate, so a writable or unsaturated size byte is caught.

// File: rtl/legacy_route_pkg.sv
package legacy_route_pkg;
  localparam int PAM_BYTES    = 7;
  localparam int NUM_REGIONS  = 2 * PAM_BYTES - 1;
  localparam int REGION_IDX_W = $clog2(NUM_REGIONS);

  localparam logic [7:0] PAM_OFS   = 8'h59;
  localparam logic [7:0] SMRAM_OFS = 8'h72;
  localparam logic [7:0] RAMSZ_OFS = 8'h57;
  localparam logic [7:0] SMRAM_RST = 8'h02;
  localparam int SMRAM_OPEN_BIT = 6;
  localparam int SMRAM_GEN_BIT  = 3;

  // attr[0]: read goes to DRAM, attr[1]: write goes to DRAM
  typedef logic [1:0] attr_t;

  typedef struct packed {
    attr_t [NUM_REGIONS-1:0] attr;
    logic                    smram_open;
    logic                    smram_gen;
  } route_map_t;

  // attribute byte (relative to PAM_OFS) holding region r
  function automatic int field_byte(int r);
    return (r + 1) / 2;
  endfunction

  // lsb of region r's field inside that byte
  function automatic int field_lsb(int r);
    return (r == 0 || (r % 2) == 0) ? 4 : 0;
  endfunction
endpackage

// File: rtl/lrd_cfg_regs.sv
module lrd_cfg_regs
  import legacy_route_pkg::*;
#(
  parameter int RAM_MB = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic [5:0]                 cfg_dw,
  input  logic [3:0]                 cfg_be,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  output logic [PAM_BYTES-1:0][7:0]  pam_next,
  output logic [7:0]                 smram_next,
  output logic                       map_load
);
  localparam int RAM_UNITS = RAM_MB / 8;
  localparam logic [7:0] RAM_CODE = (RAM_UNITS > 255) ? 8'hFF : RAM_UNITS[7:0];

  logic [PAM_BYTES-1:0][7:0] pam_q;
  logic [7:0]                smram_q;
  logic [PAM_BYTES-1:0]      pam_hit;
  logic                      smram_hit;
  logic [31:0]               rd_word;

  genvar k;
  generate
    for (k = 0; k < PAM_BYTES; k++) begin : g_pam
      localparam logic [7:0] OFS = PAM_OFS + 8'(k);
      localparam int LANE = int'(OFS[1:0]);
      assign pam_hit[k]  = cfg_wr && (cfg_dw == OFS[7:2]) && cfg_be[LANE];
      assign pam_next[k] = pam_hit[k] ? cfg_wdata[8*LANE +: 8] : pam_q[k];
    end
  endgenerate

  localparam int SM_LANE = int'(SMRAM_OFS[1:0]);
  assign smram_hit  = cfg_wr && (cfg_dw == SMRAM_OFS[7:2]) && cfg_be[SM_LANE];
  assign smram_next = smram_hit ? cfg_wdata[8*SM_LANE +: 8] : smram_q;
  assign map_load   = smram_hit | (|pam_hit);

  always_comb begin
    rd_word = '0;
    for (int j = 0; j < 4; j++) begin
      if ({cfg_dw, 2'(j)} == RAMSZ_OFS) rd_word[8*j +: 8] = RAM_CODE;
      if ({cfg_dw, 2'(j)} == SMRAM_OFS) rd_word[8*j +: 8] = smram_q;
      for (int b = 0; b < PAM_BYTES; b++) begin
        if ({cfg_dw, 2'(j)} == PAM_OFS + 8'(b)) rd_word[8*j +: 8] = pam_q[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pam_q     <= '0;
      smram_q   <= SMRAM_RST;
      cfg_rdata <= '0;
    end else begin
      pam_q     <= pam_next;
      smram_q   <= smram_next;
      cfg_rdata <= rd_word;
    end
  end

  // R1
  smram_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> smram_q == SMRAM_RST);

  // R2
  ramsize_const_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_dw) == RAMSZ_OFS[7:2])
      |-> cfg_rdata[8*int'(RAMSZ_OFS[1:0]) +: 8] == RAM_CODE);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !map_load |=> ($stable(pam_q) && $stable(smram_q)));
endmodule

// File: rtl/lrd_region_map.sv
module lrd_region_map
  import legacy_route_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [PAM_BYTES-1:0][7:0] pam_next,
  input  logic [7:0]                smram_next,
  output route_map_t                map_q
);
  route_map_t map_d;
  logic       unused_cfg_bits;

  genvar r;
  generate
    for (r = 0; r < NUM_REGIONS; r++) begin : g_field
      localparam int BYTE_I = field_byte(r);
      localparam int LSB    = field_lsb(r);
      assign map_d.attr[r] = pam_next[BYTE_I][LSB +: 2];
    end
  endgenerate

  assign map_d.smram_open = smram_next[SMRAM_OPEN_BIT];
  assign map_d.smram_gen  = smram_next[SMRAM_GEN_BIT];
  assign unused_cfg_bits  = ^{pam_next, smram_next};

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q.attr       <= '0;
      map_q.smram_open <= SMRAM_RST[SMRAM_OPEN_BIT];
      map_q.smram_gen  <= SMRAM_RST[SMRAM_GEN_BIT];
    end else if (load) begin
      map_q <= map_d;
    end
  end

  // R9
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(map_q));

  // R9
  map_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (map_q.smram_open == $past(smram_next[SMRAM_OPEN_BIT])
              && map_q.smram_gen == $past(smram_next[SMRAM_GEN_BIT])));
endmodule

// File: rtl/lrd_addr_decode.sv
module lrd_addr_decode
  import legacy_route_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEG_LOG2   = 20,
  parameter int SMRAM_BASE = 32'h000A_0000,
  parameter int SMRAM_LOG2 = 17,
  parameter int EXP_BASE   = 32'h000C_0000,
  parameter int EXP_LOG2   = 14,
  parameter int BIOS_BASE  = 32'h000F_0000,
  parameter int BIOS_LOG2  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_smm,
  input  route_map_t        map,
  output logic              route_rd_dram,
  output logic              route_wr_dram
);
  localparam int SEG_W = LEG_LOG2 - EXP_LOG2;
  localparam int SW    = LEG_LOG2 - SMRAM_LOG2;
  localparam int BW    = LEG_LOG2 - BIOS_LOG2;
  localparam int NUM_EXP = NUM_REGIONS - 1;
  localparam logic [SEG_W-1:0] EXP_FIRST = SEG_W'(EXP_BASE >> EXP_LOG2);
  localparam logic [SEG_W-1:0] EXP_LAST  = SEG_W'((EXP_BASE >> EXP_LOG2) + NUM_EXP - 1);
  localparam logic [SW-1:0]    SM_TAG    = SW'(SMRAM_BASE >> SMRAM_LOG2);
  localparam logic [BW-1:0]    BIOS_TAG  = BW'(BIOS_BASE >> BIOS_LOG2);

  logic                    in_low, smram_hit, bios_hit, exp_hit, in_legacy;
  logic [SEG_W-1:0]        seg, rel;
  logic [REGION_IDX_W-1:0] ridx;
  attr_t                   exp_attr;
  logic                    smram_dram;
  attr_t                   route_d;
  logic                    unused_addr_lo;

  assign in_low    = (mem_addr[ADDR_W-1:LEG_LOG2] == '0);
  assign seg       = mem_addr[LEG_LOG2-1:EXP_LOG2];
  assign smram_hit = in_low && (mem_addr[LEG_LOG2-1:SMRAM_LOG2] == SM_TAG);
  assign bios_hit  = in_low && (mem_addr[LEG_LOG2-1:BIOS_LOG2] == BIOS_TAG);
  assign exp_hit   = in_low && (seg >= EXP_FIRST) && (seg <= EXP_LAST);
  assign in_legacy = smram_hit | bios_hit | exp_hit;
  assign rel       = seg - EXP_FIRST;
  assign ridx      = REGION_IDX_W'(rel) + REGION_IDX_W'(1);
  assign smram_dram = map.smram_open | (mem_smm & map.smram_gen);
  assign unused_addr_lo = ^mem_addr[EXP_LOG2-1:0];

  always_comb begin
    exp_attr = '0;
    for (int r = 1; r < NUM_REGIONS; r++) begin
      if (ridx == REGION_IDX_W'(r)) exp_attr = map.attr[r];
    end
  end

  always_comb begin
    if (smram_hit)     route_d = {smram_dram, smram_dram};
    else if (bios_hit) route_d = map.attr[0];
    else if (exp_hit)  route_d = exp_attr;
    else               route_d = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_rd_dram <= 1'b0;
      route_wr_dram <= 1'b0;
    end else begin
      route_rd_dram <= route_d[0];
      route_wr_dram <= route_d[1];
    end
  end

  // R8
  outside_dram_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_legacy)) |-> (route_rd_dram && route_wr_dram));

  // R6
  smram_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(smram_hit && !mem_smm && !map.smram_open))
      |-> (!route_rd_dram && !route_wr_dram));

  // R7
  smm_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(smram_hit && mem_smm && map.smram_gen))
      |-> (route_rd_dram && route_wr_dram));

  // R5
  bios_attr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bios_hit))
      |-> ({route_wr_dram, route_rd_dram} == $past(map.attr[0])));
endmodule

// File: rtl/legacy_route_ctl.sv
module legacy_route_ctl
  import legacy_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RAM_MB = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [5:0]        cfg_dw,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_smm,
  output logic              route_rd_dram,
  output logic              route_wr_dram
);
  logic [PAM_BYTES-1:0][7:0] pam_next;
  logic [7:0]                smram_next;
  logic                      map_load;
  route_map_t                map_q;

  lrd_cfg_regs #(.RAM_MB(RAM_MB)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_dw     (cfg_dw),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .pam_next   (pam_next),
    .smram_next (smram_next),
    .map_load   (map_load)
  );

  lrd_region_map u_map (
    .clk        (clk),
    .rst        (rst),
    .load       (map_load),
    .pam_next   (pam_next),
    .smram_next (smram_next),
    .map_q      (map_q)
  );

  lrd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk           (clk),
    .rst           (rst),
    .mem_addr      (mem_addr),
    .mem_smm       (mem_smm),
    .map           (map_q),
    .route_rd_dram (route_rd_dram),
    .route_wr_dram (route_wr_dram)
  );
endmodule

// File: tb/legacy_route_ctl_bench.sv
module legacy_route_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst, cfg_wr, mem_smm;
  logic [5:0]  cfg_dw;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata, sat_rdata, mem_addr;
  logic        route_rd_dram, route_wr_dram, sat_rd, sat_wr;

  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  logic [7:0] pam_m [7];
  logic [7:0] smram_m;

  legacy_route_ctl u_legacy_route_ctl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_smm(mem_smm), .route_rd_dram(route_rd_dram), .route_wr_dram(route_wr_dram));

  legacy_route_ctl #(.RAM_MB(4096)) u_sat (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(sat_rdata), .mem_addr(mem_addr),
    .mem_smm(mem_smm), .route_rd_dram(sat_rd), .route_wr_dram(sat_wr));

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_route(logic [31:0] a, logic smm);
    logic [7:0] by;
    logic [1:0] f;
    logic d;
    int i;
    if (a < 32'hA0000 || a >= 32'h100000) return 2'b11;
    if (a < 32'hC0000) begin
      d = smram_m[6] | (smm & smram_m[3]);
      return {d, d};
    end
    if (a >= 32'hF0000) f = pam_m[0][5:4];
    else begin
      i  = int'((a - 32'hC0000) / 16384) + 1;
      by = pam_m[(i + 1) / 2];
      f  = (i % 2 == 1) ? by[1:0] : by[5:4];
    end
    return f;
  endfunction

  function automatic string req_of(logic [31:0] a, logic smm);
    if (a < 32'hA0000 || a >= 32'h100000) return "R8";
    if (a < 32'hC0000) return smm ? "R7" : "R6";
    return "R4/R5";
  endfunction

  task automatic model_write(logic [5:0] dw, logic [3:0] be, logic [31:0] data);
    for (int j = 0; j < 4; j++) begin
      logic [7:0] ofs;
      ofs = {dw, 2'(j)};
      if (be[j]) begin
        if (ofs >= 8'h59 && ofs <= 8'h5F) pam_m[ofs - 8'h59] = data[8*j +: 8];
        else if (ofs == 8'h72) smram_m = data[8*j +: 8];
      end
    end
  endtask

  task automatic cfg_write(logic [5:0] dw, logic [3:0] be, logic [31:0] data);
    cfg_dw = dw; cfg_be = be; cfg_wdata = data; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    model_write(dw, be, data);
  endtask

  task automatic read_check(logic [5:0] dw, logic [31:0] exp, string req);
    cfg_dw = dw;
    @(posedge clk); #1;
    check32(req, $sformatf("read dw=%h", dw), cfg_rdata, exp);
  endtask

  task automatic route_check(logic [31:0] a, logic smm, string req);
    string tag;
    tag = (req == "") ? req_of(a, smm) : req;
    mem_addr = a; mem_smm = smm;
    @(posedge clk); #1;
    check32(tag, $sformatf("route addr=%h smm=%0d", a, smm),
            {30'b0, route_wr_dram, route_rd_dram}, {30'b0, exp_route(a, smm)});
  endtask

  function automatic logic [31:0] word58();
    return {pam_m[2], pam_m[1], pam_m[0], 8'h00};
  endfunction
  function automatic logic [31:0] word5c();
    return {pam_m[6], pam_m[5], pam_m[4], pam_m[3]};
  endfunction
  function automatic logic [31:0] word70();
    return {8'h00, smram_m, 16'h0000};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v [7];
    logic [7:0] sm_set [4];
    sm_set[0] = 8'h02; sm_set[1] = 8'h0A; sm_set[2] = 8'h42; sm_set[3] = 8'h4A;
    for (int b = 0; b < 7; b++) pam_m[b] = 8'h00;
    smram_m = 8'h02;
    rst = 1; cfg_wr = 0; cfg_dw = 0; cfg_be = 0; cfg_wdata = 0; mem_addr = 0; mem_smm = 0;
    repeat (3) @(posedge clk);
    #1;
    check32("R1", "route outputs in reset", {30'b0, route_wr_dram, route_rd_dram}, 32'h0);
    check32("R1", "rdata in reset", cfg_rdata, 32'h0);
    rst = 0;

    // R1 reset contents and routing
    read_check(6'h1C, 32'h0002_0000, "R1");
    read_check(6'h16, 32'h0, "R1");
    route_check(32'hA0000, 1'b0, "R1");
    route_check(32'hB8000, 1'b1, "R1");
    route_check(32'hF4000, 1'b0, "R1");
    route_check(32'hC4000, 1'b1, "R1");

    // R2 size byte, read-only and saturation
    cfg_dw = 6'h15;
    @(posedge clk); #1;
    check32("R2", "size byte", cfg_rdata, 32'h4000_0000);
    check32("R2", "size saturated", sat_rdata, 32'hFF00_0000);
    cfg_write(6'h15, 4'hF, 32'hFFFF_FFFF);
    read_check(6'h15, 32'h4000_0000, "R2");

    // R3 byte enables and unimplemented offsets
    cfg_write(6'h16, 4'b0001, 32'hFFFF_FFFF);
    read_check(6'h16, word58(), "R3");
    cfg_write(6'h16, 4'b1110, 32'h3322_1100);
    read_check(6'h16, 32'h3322_1100, "R3");
    cfg_write(6'h17, 4'b0000, 32'hFFFF_FFFF);
    read_check(6'h17, 32'h0, "R3");
    cfg_write(6'h18, 4'hF, 32'hFFFF_FFFF);
    read_check(6'h18, 32'h0, "R3");

    // R4 reserved low nibble of the first attribute byte
    cfg_write(6'h16, 4'b0010, 32'h0000_0F00);
    route_check(32'hF0000, 1'b0, "R4");
    route_check(32'hFFFFF, 1'b1, "R4");
    cfg_write(6'h16, 4'b0010, 32'h0000_3000);
    route_check(32'hF0000, 1'b0, "R4");
    route_check(32'hF8000, 1'b1, "R5");

    // Sweep: attribute patterns x SMRAM modes x all segments
    for (int p = 0; p < 10; p++) begin
      for (int b = 0; b < 7; b++)
        v[b] = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'((p * 53 + b * 71 + 19) & 255);
      cfg_write(6'h16, 4'b1110, {v[2], v[1], v[0], 8'h00});
      cfg_write(6'h17, 4'hF, {v[6], v[5], v[4], v[3]});
      cfg_write(6'h1C, 4'b0100, {8'h00, sm_set[p % 4], 16'h0000});
      read_check(6'h16, word58(), "R3");
      read_check(6'h17, word5c(), "R3");
      read_check(6'h1C, word70(), "R3");
      for (int r = 0; r < 13; r++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] a;
          if (r == 0) a = 32'hF0000 + 32'((r * 5123 + p * 977 + s * 31) & 16'hFFFF);
          else a = 32'hC0000 + 32'((r - 1) * 16384) + 32'((r * 5123 + p * 77 + s) & 14'h3FFF);
          if (p % 2 == 1) a = (r == 0) ? 32'hFFFFF : 32'hC0000 + 32'(r * 16384) - 1;
          route_check(a, s[0], "");
        end
      end
      for (int s = 0; s < 2; s++) begin
        route_check(32'hA0000, s[0], "");
        route_check(32'hBFFFF, s[0], "");
        route_check(32'h9FFFF, s[0], "");
        route_check(32'h100000, s[0], "");
        route_check(32'h0, s[0], "");
        route_check(32'hFFFF_FFFF, s[0], "");
        route_check(32'h80F_0000, s[0], "R8");
      end
    end

    // R9 same-edge request uses old map
    cfg_write(6'h1C, 4'b0100, 32'h0002_0000);
    cfg_write(6'h16, 4'b1000, 32'h0000_0000);
    route_check(32'hC8000, 1'b0, "R9");
    mem_addr = 32'hC8000; mem_smm = 0;
    cfg_dw = 6'h16; cfg_be = 4'b1000; cfg_wdata = 32'h0300_0000; cfg_wr = 1;
    @(posedge clk); #1;
    cfg_wr = 0;
    check32("R9", "route same edge as write", {30'b0, route_wr_dram, route_rd_dram}, 32'h0);
    model_write(6'h16, 4'b1000, 32'h0300_0000);
    @(posedge clk); #1;
    check32("R9", "route after write", {30'b0, route_wr_dram, route_rd_dram}, 32'h3);

    // R9 writes outside the trigger bytes leave routing
    cfg_write(6'h1C, 4'b1011, 32'hFFFF_FFFF);
    cfg_write(6'h16, 4'b0001, 32'h0000_00FF);
    cfg_write(6'h14, 4'hF, 32'hFFFF_FFFF);
    route_check(32'hC8000, 1'b0, "R9");
    route_check(32'hA4000, 1'b0, "R9");
    route_check(32'hA4000, 1'b1, "R9");
    read_check(6'h1C, 32'h0002_0000, "R9");

    // R10 outputs registered, steady between edges
    route_check(32'hC8000, 1'b0, "R10");
    mem_addr = 32'hA0000;
    #3;
    check32("R10", "hold between edges", {30'b0, route_wr_dram, route_rd_dram}, 32'h3);
    @(posedge clk); #1;
    check32("R10", "after edge", {30'b0, route_wr_dram, route_rd_dram}, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule